// File: doc/BRIEF.md
# Loopback 2 ACT Bit Controller

This block sits in the transmit path of a line-side network termination. It decides, once per frame, what goes upstream toward the exchange: the normal 2B+D word and ACT bit, or a loopback of the 2B+D word that arrived from the exchange. A loopback 2 request is taken from one of two places. When automatic maintenance-channel processing is on, the request comes from that processor's command output. Otherwise it comes from a manual control bit.

Two handshake styles are supported, and the style is chosen by a mode input. In immediate mode, the loopback starts on the first frame of the request, and the transmitted ACT bit is held at 0. In acknowledged mode, the controller first sends an all-ones word upstream, with ACT following the terminal-side activity flag. It closes the loop only after the far end answers with ACT = 1. The mode is captured when a loopback starts, and later changes to it are not used until the loopback ends.

The 2B+D word is 18 bits wide. Bits [17:10] are the first B channel, bits [9:2] are the second B channel, and bits [1:0] are the D channel. Every output register updates only on a frame strobe.

Top module: `lb2_act_ctrl`

## Requirements
- R1: A frame strobe that finds the controller idle, with the request high and `mode_immediate` = 1, moves it to looped. From that strobe on, `up_data` equals the `dn_data` sampled at each strobe, and `tx_act` = 0.
- R2: A frame strobe that finds the controller idle, with the request high and `mode_immediate` = 0, moves it to waiting. While waiting, `up_data` is all ones (18'h3FFFF), and `tx_act` equals the `info3_seen` value sampled at each strobe.
- R3: While waiting, a strobe with `rx_act` = 1 and the request still high moves the controller to looped, in that same strobe. `up_data` then equals the `dn_data` sampled at that strobe, and `tx_act` equals `info3_seen`.
- R4: A strobe with the request low returns the controller to idle from any state. The outputs of that same strobe already carry the pass-through values.
- R5: While idle, each strobe loads `up_data` from `up_src` and `tx_act` from `act_src`.
- R6: The request is `eoc_lb_cmd` when `auto_eoc_en` = 1, and `man_lb` when `auto_eoc_en` = 0. The input that is not selected has no effect.
- R7: The value of `mode_immediate` is captured on the strobe that leaves idle. Changes to `mode_immediate` while waiting or looped do not change `tx_act`, `up_data` or the next state.
- R8: `up_data` and `tx_act` change only on clock edges where `frame_stb` = 1.
- R9: While reset is applied, and after reset until the first strobe, the controller is idle, `up_data` is all ones and `tx_act` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_stb | input | 1 | One-cycle strobe, once per 2B+D frame |
| auto_eoc_en | input | 1 | 1: request comes from the maintenance processor |
| eoc_lb_cmd | input | 1 | Loopback 2 command from the maintenance processor |
| man_lb | input | 1 | Manual loopback 2 control bit |
| mode_immediate | input | 1 | 1: immediate loop with ACT = 0; 0: acknowledged loop |
| info3_seen | input | 1 | Terminal side is recognized as active |
| rx_act | input | 1 | ACT bit received from the far end |
| act_src | input | 1 | Normal ACT bit used outside loopback |
| dn_data | input | 18 | 2B+D word received from the far end |
| up_src | input | 18 | Normal upstream 2B+D word |
| tx_act | output | 1 | Transmitted ACT bit |
| up_data | output | 18 | Upstream 2B+D word |

## Verification
The bench builds the block with its default lane parameters: two 8-bit B lanes and a 2-bit D lane. This gives the 18-bit word, so the distinct patterns written into each lane show whether every lane follows the same source selection. With these values, every state transition can be reached within a few frames, including the mode being changed in the middle of a wait and in the middle of a loop. It also brings within reach the request source being switched while a loopback is active, and reset being applied in the middle of a loopback.

// File: rtl/lb2_pkg.sv
package lb2_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_LOOP = 2'd2
  } lb2_state_e;

  typedef enum logic [1:0] {
    PICK_NORMAL = 2'd0,
    PICK_ONES   = 2'd1,
    PICK_LOOP   = 2'd2
  } lb2_pick_e;

  // next state for one frame strobe
  function automatic lb2_state_e lb2_next(input lb2_state_e cur, input logic req,
                                          input logic imm, input logic far_act);
    lb2_state_e n;
    n = ST_IDLE;
    if (req) begin
      case (cur)
        ST_IDLE: n = imm ? ST_LOOP : ST_WAIT;
        ST_WAIT: n = far_act ? ST_LOOP : ST_WAIT;
        ST_LOOP: n = ST_LOOP;
        default: n = ST_IDLE;
      endcase
    end
    return n;
  endfunction

  // transmitted ACT bit for a given state
  function automatic logic lb2_act(input lb2_state_e st, input logic imm,
                                   input logic info3, input logic normal_act);
    logic a;
    case (st)
      ST_WAIT: a = info3;
      ST_LOOP: a = imm ? 1'b0 : info3;
      default: a = normal_act;
    endcase
    return a;
  endfunction

  // upstream source for a given state
  function automatic lb2_pick_e lb2_pick(input lb2_state_e st);
    lb2_pick_e p;
    case (st)
      ST_WAIT: p = PICK_ONES;
      ST_LOOP: p = PICK_LOOP;
      default: p = PICK_NORMAL;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/lb2_req_sel.sv
module lb2_req_sel (
  input  logic auto_eoc_en,
  input  logic eoc_lb_cmd,
  input  logic man_lb,
  output logic req
);
  always_comb req = auto_eoc_en ? eoc_lb_cmd : man_lb;
endmodule

// File: rtl/lb2_fsm.sv
module lb2_fsm
  import lb2_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_stb,
  input  logic       req,
  input  logic       mode_immediate,
  input  logic       rx_act,
  output lb2_state_e state_q,
  output lb2_state_e state_nxt,
  output logic       mode_q,
  output logic       mode_eff
);
  // mode is live only while idle; captured on the strobe that leaves idle
  always_comb mode_eff = (state_q == ST_IDLE) ? mode_immediate : mode_q;

  always_comb begin
    state_nxt = state_q;
    if (frame_stb) state_nxt = lb2_next(state_q, req, mode_eff, rx_act);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      mode_q  <= 1'b1;
    end else if (frame_stb) begin
      state_q <= state_nxt;
      if (state_q == ST_IDLE) mode_q <= mode_immediate;
    end
  end

  // R4: a low request at a strobe always lands in idle
  p_drop_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_stb && !req) |=> (state_q == ST_IDLE));

  // R3: far-end acknowledge closes the loop at that strobe
  p_ack_closes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_stb && req && rx_act && state_q == ST_WAIT) |=> (state_q == ST_LOOP));
endmodule

// File: rtl/lb2_datapath.sv
module lb2_datapath
  import lb2_pkg::*;
#(
  parameter int B_W   = 8,
  parameter int NUM_B = 2,
  parameter int D_W   = 2,
  localparam int W    = NUM_B * B_W + D_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           frame_stb,
  input  lb2_state_e     state_nxt,
  input  logic           mode_eff,
  input  logic           info3_seen,
  input  logic           act_src,
  input  logic [W-1:0]   dn_data,
  input  logic [W-1:0]   up_src,
  output logic           tx_act,
  output logic [W-1:0]   up_data
);
  lb2_pick_e pick;
  logic      act_d;

  always_comb begin
    pick  = lb2_pick(state_nxt);
    act_d = lb2_act(state_nxt, mode_eff, info3_seen, act_src);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         tx_act <= 1'b0;
    else if (frame_stb) tx_act <= act_d;
  end

  // one register per B lane, highest lane first
  for (genvar i = 0; i < NUM_B; i++) begin : g_blane
    localparam int HI = W - 1 - i * B_W;
    logic [B_W-1:0] lane_d;
    always_comb begin
      case (pick)
        PICK_LOOP: lane_d = dn_data[HI -: B_W];
        PICK_ONES: lane_d = '1;
        default:   lane_d = up_src[HI -: B_W];
      endcase
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         up_data[HI -: B_W] <= '1;
      else if (frame_stb) up_data[HI -: B_W] <= lane_d;
    end
  end

  // D lane at the bottom of the word
  logic [D_W-1:0] dlane_d;
  always_comb begin
    case (pick)
      PICK_LOOP: dlane_d = dn_data[D_W-1:0];
      PICK_ONES: dlane_d = '1;
      default:   dlane_d = up_src[D_W-1:0];
    endcase
  end
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         up_data[D_W-1:0] <= '1;
    else if (frame_stb) up_data[D_W-1:0] <= dlane_d;
  end

  // R8: outputs move only on strobe edges
  p_hold_between_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_stb |=> ($stable(up_data) && $stable(tx_act)));

  // R1 / R3: entering the looped state carries the sampled downstream word
  p_loop_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_stb && state_nxt == ST_LOOP) |=> (up_data == $past(dn_data)));
endmodule

// File: rtl/lb2_act_ctrl.sv
module lb2_act_ctrl
  import lb2_pkg::*;
#(
  parameter int B_W   = 8,
  parameter int NUM_B = 2,
  parameter int D_W   = 2,
  localparam int W    = NUM_B * B_W + D_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         frame_stb,
  input  logic         auto_eoc_en,
  input  logic         eoc_lb_cmd,
  input  logic         man_lb,
  input  logic         mode_immediate,
  input  logic         info3_seen,
  input  logic         rx_act,
  input  logic         act_src,
  input  logic [W-1:0] dn_data,
  input  logic [W-1:0] up_src,
  output logic         tx_act,
  output logic [W-1:0] up_data
);
  logic       req;
  lb2_state_e state_q;
  lb2_state_e state_nxt;
  logic       mode_q;
  logic       mode_eff;

  lb2_req_sel u_req (
    .auto_eoc_en (auto_eoc_en),
    .eoc_lb_cmd  (eoc_lb_cmd),
    .man_lb      (man_lb),
    .req         (req)
  );

  lb2_fsm u_fsm (
    .clk            (clk),
    .rst_n          (rst_n),
    .frame_stb      (frame_stb),
    .req            (req),
    .mode_immediate (mode_immediate),
    .rx_act         (rx_act),
    .state_q        (state_q),
    .state_nxt      (state_nxt),
    .mode_q         (mode_q),
    .mode_eff       (mode_eff)
  );

  lb2_datapath #(.B_W(B_W), .NUM_B(NUM_B), .D_W(D_W)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_stb  (frame_stb),
    .state_nxt  (state_nxt),
    .mode_eff   (mode_eff),
    .info3_seen (info3_seen),
    .act_src    (act_src),
    .dn_data    (dn_data),
    .up_src     (up_src),
    .tx_act     (tx_act),
    .up_data    (up_data)
  );

  // R2: waiting always shows all ones upstream
  p_wait_ones_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT) |-> (up_data == {W{1'b1}}));

  // R1: a loop opened in immediate mode keeps ACT low
  p_imm_act_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LOOP && mode_q) |-> !tx_act);

  // R9: idle before any strobe after reset shows reset values
  p_reset_vals_r9: assert property (@(posedge clk)
    !rst_n |=> (state_q == ST_IDLE));
endmodule

// File: tb/lb2_act_ctrl_tb.sv
module lb2_act_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W = 18;
  localparam int NV = 14;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_stb = 1'b0;
  logic auto_eoc_en = 1'b0, eoc_lb_cmd = 1'b0, man_lb = 1'b0;
  logic mode_immediate = 1'b0, info3_seen = 1'b0, rx_act = 1'b0, act_src = 1'b0;
  logic [W-1:0] dn_data = '0, up_src = '0;
  logic tx_act;
  logic [W-1:0] up_data;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lb2_act_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb),
    .auto_eoc_en(auto_eoc_en), .eoc_lb_cmd(eoc_lb_cmd), .man_lb(man_lb),
    .mode_immediate(mode_immediate), .info3_seen(info3_seen), .rx_act(rx_act),
    .act_src(act_src), .dn_data(dn_data), .up_src(up_src),
    .tx_act(tx_act), .up_data(up_data)
  );

  // ctl bits: auto, eoc, man, mode, info3, rx_act, act_src, spare
  // vector: ctl[62:55] dn[54:37] up_src[36:19] exp_act[18] exp_up[17:0]
  localparam logic [62:0] VEC [NV] = '{
    {8'b0000_0010, 18'h0A5A5, 18'h12345, 1'b1, 18'h12345}, // R5 idle pass
    {8'b0011_0000, 18'h0A5A5, 18'h00001, 1'b0, 18'h0A5A5}, // R1 immediate loop
    {8'b0010_1000, 18'h03C3C, 18'h00002, 1'b0, 18'h03C3C}, // R7 mode flip ignored
    {8'b0000_0000, 18'h3FF00, 18'h11111, 1'b0, 18'h11111}, // R4 drop to idle
    {8'b0010_0000, 18'h00F0F, 18'h00003, 1'b0, 18'h3FFFF}, // R2 wait, info3 low
    {8'b0010_1000, 18'h00F0F, 18'h00003, 1'b1, 18'h3FFFF}, // R2 wait, info3 high
    {8'b0011_1000, 18'h01234, 18'h00004, 1'b1, 18'h3FFFF}, // R7 mode flip in wait
    {8'b0010_1100, 18'h2AAAA, 18'h00005, 1'b1, 18'h2AAAA}, // R3 ack closes loop
    {8'b0010_1000, 18'h15555, 18'h00006, 1'b1, 18'h15555}, // R3 stays looped
    {8'b1010_0010, 18'h15555, 18'h0F0F0, 1'b1, 18'h0F0F0}, // R6 auto: man ignored
    {8'b1101_0000, 18'h00FF0, 18'h00007, 1'b0, 18'h00FF0}, // R6 auto cmd loops
    {8'b0100_0000, 18'h00FF0, 18'h3C3C3, 1'b0, 18'h3C3C3}, // R6 manual: cmd ignored
    {8'b0010_0000, 18'h0000F, 18'h00008, 1'b0, 18'h3FFFF}, // R2 wait again
    {8'b0000_0110, 18'h0000F, 18'h2468A, 1'b1, 18'h2468A}  // R4 wait to idle
  };

  task automatic check(input string req, input logic a_act, input logic [W-1:0] a_up,
                       input logic e_act, input logic [W-1:0] e_up);
    n_chk++;
    if (a_act !== e_act || a_up !== e_up) begin
      n_bad++;
      $display("FAIL %s: act=%b up=%h expected act=%b up=%h", req, a_act, a_up, e_act, e_up);
    end
  endtask

  task automatic strobe();
    frame_stb = 1'b1;
    @(negedge clk);
    frame_stb = 1'b0;
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: act=%b up=%h expected act=x up=x", tx_act, up_data);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9 in reset", tx_act, up_data, 1'b0, 18'h3FFFF);
    rst_n = 1'b1;
    act_src = 1'b1;
    up_src = 18'h13579;
    repeat (2) @(negedge clk);
    check("R9 after reset", tx_act, up_data, 1'b0, 18'h3FFFF);

    for (int k = 0; k < NV; k++) begin
      {auto_eoc_en, eoc_lb_cmd, man_lb, mode_immediate, info3_seen, rx_act, act_src} = VEC[k][62:56];
      dn_data = VEC[k][54:37];
      up_src  = VEC[k][36:19];
      strobe();
      check($sformatf("vector %0d", k), tx_act, up_data, VEC[k][18], VEC[k][17:0]);
    end

    // R8: no strobe, inputs move, outputs hold (idle now, passing 2468A)
    up_src = 18'h00000; act_src = 1'b0; man_lb = 1'b1; mode_immediate = 1'b1;
    repeat (4) @(negedge clk);
    check("R8 hold without strobe", tx_act, up_data, 1'b1, 18'h2468A);

    // R1 then R8 in loop: dn changes without strobe
    dn_data = 18'h0C0C0;
    strobe();
    check("R1 loop entry", tx_act, up_data, 1'b0, 18'h0C0C0);
    dn_data = 18'h30303;
    repeat (3) @(negedge clk);
    check("R8 loop hold", tx_act, up_data, 1'b0, 18'h0C0C0);

    // R9: reset mid-loop, then idle pass-through at next strobe
    rst_n = 1'b0;
    @(negedge clk);
    check("R9 reset mid-loop", tx_act, up_data, 1'b0, 18'h3FFFF);
    rst_n = 1'b1;
    man_lb = 1'b0; act_src = 1'b1; up_src = 18'h01010;
    strobe();
    check("R5 idle after reset", tx_act, up_data, 1'b1, 18'h01010);

    // R3: ack with info3 low gives loop with ACT low in acknowledged mode
    man_lb = 1'b1; mode_immediate = 1'b0; info3_seen = 1'b0; rx_act = 1'b0;
    strobe();
    check("R2 wait entry", tx_act, up_data, 1'b0, 18'h3FFFF);
    rx_act = 1'b1; dn_data = 18'h1E1E1;
    strobe();
    check("R3 ack, info3 low", tx_act, up_data, 1'b0, 18'h1E1E1);
    info3_seen = 1'b1;
    strobe();
    check("R3 info3 raises act", tx_act, up_data, 1'b1, 18'h1E1E1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule